// File: doc/BRIEF.md
# Tag Compare and Fill Controller

This block is the lookup path of a synchronous cache tag store. On each rising clock edge it samples a set of active-low controls, an address and an 18-bit input word (16 data bits and 2 parity bits). It then carries out one of four operations on a small word-addressed array. A read presents a stored word. A write stores the input word. A compare checks the stored word at the sampled address against the input word and reports a hit or a miss. A fill write stores a tag that was captured earlier.

The input word is held in a data register that reloads only on edges where data enable is active. A tag that misses in a compare therefore stays in that register, and a following fill write can store it without the bus presenting it again. The result stage runs in one of two modes. In flow-through mode, read data and the match flag come straight from the sampled state in the cycle after the sampling edge. In pipeline mode they pass through one more register and appear one cycle later. The tri-state pins are modelled as a value plus a drive-enable flag.

Top module: `tagcmp_top`

## Requirements
- R1: The chip is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. Any other combination is a deselect: nothing is written and the match flag reads 1.
- R2: The data register loads `din` on every edge where `den_n`=0, whether the chip is selected or not. On edges where `den_n`=1 it keeps its value.
- R3: Write (selected, `wr_n`=0, `den_n`=0) stores `din` at `addr` on the sampling edge.
- R4: Fill write (selected, `wr_n`=0, `den_n`=1) stores the value held in the data register at `addr`, not the word on `din`.
- R5: Read (selected, `wr_n`=1, `oe_n`=0) sets `rd_oe`=1 and presents the word stored at `addr` on `rd_data`.
- R6: Compare (selected, `wr_n`=1, `den_n`=0, `oe_n`=1) sets `mt_out`=1 when all 18 bits of the stored word equal `din`. A difference in any bit, including the parity bits 17:16, gives `mt_out`=0.
- R7: For any sampled operation other than a compare, `mt_out` reads 1.
- R8: `oe_n`=1 forces `rd_oe`=0, and `moe_n`=1 forces `mt_oe`=0, in the same cycle without a clock edge. `mt_oe` is 1 while `moe_n`=0.
- R9: With `pipe_mode`=0, results of the operation sampled at edge N are valid between edge N and edge N+1.
- R10: With `pipe_mode`=1, results of the operation sampled at edge N are valid between edge N+1 and edge N+2.
- R11: After synchronous reset the result stages report no read (`rd_oe`=0) and `mt_out`=1, and the data register is cleared.
- R12: A fill write issued right after a compare that missed at the same address does not change that compare's reported result. A later compare of the same tag hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en_a_n | input | 1 | Select term, active low |
| en_b | input | 1 | Select term, active high |
| en_c_n | input | 1 | Select term, active low |
| wr_n | input | 1 | Combined write strobe, active low |
| den_n | input | 1 | Data register load enable, active low |
| oe_n | input | 1 | Read data drive enable, active low |
| moe_n | input | 1 | Match drive enable, active low |
| pipe_mode | input | 1 | 1 = pipeline results, 0 = flow-through |
| addr | input | AW | Word address |
| din | input | WORD_W | Input word: data plus parity |
| rd_data | output | WORD_W | Read data value |
| rd_oe | output | 1 | Read data is being driven |
| mt_out | output | 1 | Match value: 1 hit or idle, 0 miss |
| mt_oe | output | 1 | Match is being driven |

## Verification
Two operations can meet in the same cycle: a compare that misses, and the fill write that repairs the entry. In pipeline mode the fill write is sampled on the same edge that moves the compare's miss into the output register. The bench issues compare and fill back to back at one address, with unrelated values on `din` during the fill. It expects the miss to appear while the fill is already in the array, and a repeat compare of the tag to hit. The same pair is also run in flow-through mode. There the fill must not disturb the reported miss, and the final read must return the captured tag.

// File: rtl/tagcmp_pkg.sv
`timescale 1ns/1ps
package tagcmp_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_CMP   = 3'd3,
    OP_FILL  = 3'd4,
    OP_NOP   = 3'd5
  } op_e;
endpackage

// File: rtl/tagcmp_decode.sv
`timescale 1ns/1ps
module tagcmp_decode
  import tagcmp_pkg::*;
(
  input  logic en_a_n,
  input  logic en_b,
  input  logic en_c_n,
  input  logic wr_n,
  input  logic den_n,
  input  logic oe_n,
  output logic sel,
  output op_e  op
);
  always_comb begin
    sel = !en_a_n && en_b && !en_c_n;
    if (!sel)        op = OP_IDLE;
    else if (!wr_n)  op = den_n ? OP_FILL : OP_WRITE;
    else if (!oe_n)  op = OP_READ;
    else if (!den_n) op = OP_CMP;
    else             op = OP_NOP;
  end
endmodule

// File: rtl/tagcmp_store.sv
`timescale 1ns/1ps
module tagcmp_store #(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  // read-first single port, inferable as block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

  // R3 R4
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(addr)] == $past(wdata)))
    else $error("stored word does not match written word");
endmodule

// File: rtl/tagcmp_outstage.sv
`timescale 1ns/1ps
module tagcmp_outstage
  import tagcmp_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_mode,
  input  op_e               s1_op,
  input  logic [WORD_W-1:0] s1_word,
  input  logic [WORD_W-1:0] s1_ref,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_is_read,
  output logic              mt_raw
);
  localparam int NLANE = (WORD_W + LANE_W - 1) / LANE_W;

  logic [NLANE-1:0] lane_eq;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LO = g * LANE_W;
    localparam int HI = ((LO + LANE_W) > WORD_W) ? (WORD_W - 1) : (LO + LANE_W - 1);
    assign lane_eq[g] = (s1_word[HI:LO] == s1_ref[HI:LO]);
  end

  logic s1_hit;
  logic s1_isread;
  assign s1_hit    = (s1_op == OP_CMP) ? (&lane_eq) : 1'b1;
  assign s1_isread = (s1_op == OP_READ);

  logic [WORD_W-1:0] s2_word;
  logic              s2_isread;
  logic              s2_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_word   <= '0;
      s2_isread <= 1'b0;
      s2_hit    <= 1'b1;
    end else begin
      s2_word   <= s1_word;
      s2_isread <= s1_isread;
      s2_hit    <= s1_hit;
    end
  end

  always_comb begin
    if (pipe_mode) begin
      rd_word    = s2_word;
      rd_is_read = s2_isread;
      mt_raw     = s2_hit;
    end else begin
      rd_word    = s1_word;
      rd_is_read = s1_isread;
      mt_raw     = s1_hit;
    end
  end

  // R10
  pipe_delay_chk: assert property (@(posedge clk) disable iff (rst)
    pipe_mode |-> (mt_raw == $past(s1_hit)))
    else $error("pipeline match not delayed by one stage");
endmodule

// File: rtl/tagcmp_top.sv
`timescale 1ns/1ps
module tagcmp_top
  import tagcmp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAR_W  = 2,
  parameter int DEPTH  = 16,
  parameter int LANE_W = 9,
  localparam int WORD_W = DATA_W + PAR_W,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic              en_c_n,
  input  logic              wr_n,
  input  logic              den_n,
  input  logic              oe_n,
  input  logic              moe_n,
  input  logic              pipe_mode,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              mt_out,
  output logic              mt_oe
);
  logic sel;
  op_e  op;

  tagcmp_decode u_dec (
    .en_a_n (en_a_n),
    .en_b   (en_b),
    .en_c_n (en_c_n),
    .wr_n   (wr_n),
    .den_n  (den_n),
    .oe_n   (oe_n),
    .sel    (sel),
    .op     (op)
  );

  // data input register: loads only on data-enable edges
  logic [WORD_W-1:0] din_q;
  always_ff @(posedge clk) begin
    if (rst)         din_q <= '0;
    else if (!den_n) din_q <= din;
  end

  logic              we;
  logic [WORD_W-1:0] wdata;
  assign we    = (op == OP_WRITE) || (op == OP_FILL);
  assign wdata = den_n ? din_q : din;

  op_e s1_op;
  always_ff @(posedge clk) begin
    if (rst) s1_op <= OP_IDLE;
    else     s1_op <= op;
  end

  logic [WORD_W-1:0] mem_q;

  tagcmp_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .addr  (addr),
    .wdata (wdata),
    .rdata (mem_q)
  );

  logic [WORD_W-1:0] rd_word;
  logic              rd_is_read;
  logic              mt_raw;

  tagcmp_outstage #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .pipe_mode  (pipe_mode),
    .s1_op      (s1_op),
    .s1_word    (mem_q),
    .s1_ref     (din_q),
    .rd_word    (rd_word),
    .rd_is_read (rd_is_read),
    .mt_raw     (mt_raw)
  );

  // output enables act combinationally, unregistered
  assign rd_data = rd_word;
  assign rd_oe   = !oe_n && rd_is_read;
  assign mt_out  = mt_raw;
  assign mt_oe   = !moe_n;

  // R2
  din_hold_chk: assert property (@(posedge clk) disable iff (rst)
    den_n |=> $stable(din_q))
    else $error("data register changed without data enable");

  // R2
  din_load_chk: assert property (@(posedge clk) disable iff (rst)
    !den_n |=> (din_q == $past(din)))
    else $error("data register missed a load");

  // R1 R7
  desel_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel && !pipe_mode) |=> (pipe_mode || mt_out))
    else $error("match low after deselect");
endmodule

// File: tb/tb_tagcmp_top.sv
`timescale 1ns/1ps
module tb_tagcmp_top;
  localparam int AW = 4;
  localparam int W  = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_a_n = 1'b1, en_b = 1'b1, en_c_n = 1'b0;
  logic wr_n = 1'b1, den_n = 1'b1, oe_n = 1'b1, moe_n = 1'b0;
  logic pipe_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  din  = '0;
  logic [W-1:0]  rd_data;
  logic rd_oe, mt_out, mt_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tagcmp_top dut (
    .clk(clk), .rst(rst), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .wr_n(wr_n), .den_n(den_n), .oe_n(oe_n), .moe_n(moe_n),
    .pipe_mode(pipe_mode), .addr(addr), .din(din),
    .rd_data(rd_data), .rd_oe(rd_oe), .mt_out(mt_out), .mt_oe(mt_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic a_n, input logic b, input logic c_n,
                       input logic w_n, input logic d_n, input logic o_n,
                       input logic [AW-1:0] ad, input logic [W-1:0] d);
    en_a_n = a_n; en_b = b; en_c_n = c_n;
    wr_n = w_n; den_n = d_n; oe_n = o_n; addr = ad; din = d;
    @(posedge clk); #1;
  endtask

  task automatic op_idle();                                     apply(1,1,0,1,1,1,'0,'0); endtask
  task automatic op_idle_oe();                                  apply(1,1,0,1,1,0,'0,'0); endtask
  task automatic op_write(input logic [AW-1:0] a, input logic [W-1:0] d); apply(0,1,0,0,0,1,a,d); endtask
  task automatic op_read(input logic [AW-1:0] a);               apply(0,1,0,1,1,0,a,'0); endtask
  task automatic op_cmp(input logic [AW-1:0] a, input logic [W-1:0] d);   apply(0,1,0,1,0,1,a,d); endtask
  task automatic op_fill(input logic [AW-1:0] a, input logic [W-1:0] junk); apply(0,1,0,0,1,1,a,junk); endtask

  task automatic read_flow(input string req, input logic [AW-1:0] a, input logic [W-1:0] exp);
    op_read(a);
    chk({req, " rd_oe"}, 32'(rd_oe), 32'd1);
    chk({req, " rd_data"}, 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R11 match after reset", 32'(mt_out), 32'd1);
    chk("R11 no read after reset", 32'(rd_oe), 32'd0);
    op_idle();
    chk("R8 mt_oe with moe_n low", 32'(mt_oe), 32'd1);
    chk("R7 match on idle", 32'(mt_out), 32'd1);
  endtask

  task automatic t_write_read();
    op_write(4'd3, 18'h2A5C3);
    chk("R7 match after write", 32'(mt_out), 32'd1);
    op_write(4'd5, 18'h10F0F);
    op_idle();
    read_flow("R5 R9 R3 addr3", 4'd3, 18'h2A5C3);
    read_flow("R5 R9 R3 addr5", 4'd5, 18'h10F0F);
  endtask

  task automatic t_deselect();
    apply(1,1,0,0,0,1,4'd3,18'h00BAD);
    chk("R1 match high, en_a off", 32'(mt_out), 32'd1);
    chk("R1 no read when deselected", 32'(rd_oe), 32'd0);
    apply(0,0,0,0,0,1,4'd3,18'h00BAD);
    chk("R1 match high, en_b off", 32'(mt_out), 32'd1);
    apply(0,1,1,0,0,1,4'd3,18'h00BAD);
    read_flow("R1 no write while deselected", 4'd3, 18'h2A5C3);
  endtask

  task automatic t_compare();
    op_cmp(4'd3, 18'h2A5C3);
    chk("R6 hit equal word", 32'(mt_out), 32'd1);
    op_cmp(4'd3, 18'h2A5C3 ^ 18'h00001);
    chk("R6 miss data bit 0", 32'(mt_out), 32'd0);
    op_cmp(4'd3, 18'h2A5C3 ^ 18'h20000);
    chk("R6 miss parity bit 17", 32'(mt_out), 32'd0);
    op_cmp(4'd5, 18'h10F0F ^ 18'h10000);
    chk("R6 miss parity bit 16", 32'(mt_out), 32'd0);
  endtask

  task automatic t_hold_fill();
    op_cmp(4'd3, 18'h2A5C3 ^ 18'h20000);
    apply(1,1,0,1,1,1,4'd0,18'h3FFFF);
    op_fill(4'd6, 18'h15555);
    read_flow("R2 R4 fill uses held word", 4'd6, 18'h2A5C3 ^ 18'h20000);
    apply(1,1,0,1,0,1,4'd0,18'h0C0DE);
    op_fill(4'd7, 18'h3FFFF);
    read_flow("R2 load while deselected", 4'd7, 18'h0C0DE);
  endtask

  task automatic t_enables();
    op_read(4'd5);
    chk("R8 rd_oe before", 32'(rd_oe), 32'd1);
    oe_n = 1'b1; #1;
    chk("R8 oe_n high drops rd_oe", 32'(rd_oe), 32'd0);
    moe_n = 1'b1; #1;
    chk("R8 moe_n high drops mt_oe", 32'(mt_oe), 32'd0);
    oe_n = 1'b0; moe_n = 1'b0; #0.5;
    chk("R8 rd_oe restored", 32'(rd_oe), 32'd1);
    chk("R8 mt_oe restored", 32'(mt_oe), 32'd1);
  endtask

  task automatic t_pipeline();
    op_idle();
    pipe_mode = 1'b1;
    op_idle();
    op_cmp(4'd3, 18'h2A5C3 ^ 18'h00002);
    chk("R10 match not yet updated", 32'(mt_out), 32'd1);
    op_idle();
    chk("R10 miss one cycle later", 32'(mt_out), 32'd0);
    op_idle();
    chk("R10 idle after miss", 32'(mt_out), 32'd1);
    op_read(4'd5);
    chk("R10 read not yet visible", 32'(rd_oe), 32'd0);
    op_idle_oe();
    chk("R10 R5 pipelined rd_oe", 32'(rd_oe), 32'd1);
    chk("R10 R5 pipelined rd_data", 32'(rd_data), 32'h10F0F);
    op_idle();
  endtask

  task automatic t_collide();
    pipe_mode = 1'b0;
    op_idle();
    op_write(4'd9, 18'h1ABCD);
    op_cmp(4'd9, 18'h01234);
    chk("R12 flow miss", 32'(mt_out), 32'd0);
    op_fill(4'd9, 18'h3FFFF);
    chk("R12 R7 flow fill reports high", 32'(mt_out), 32'd1);
    op_cmp(4'd9, 18'h01234);
    chk("R12 flow re-compare hits", 32'(mt_out), 32'd1);
    read_flow("R12 R4 flow filled word", 4'd9, 18'h01234);
    op_idle();
    pipe_mode = 1'b1;
    op_idle();
    op_write(4'd10, 18'h1ABCD);
    op_cmp(4'd10, 18'h2FACE);
    chk("R12 pipe write stage high", 32'(mt_out), 32'd1);
    op_fill(4'd10, 18'h00000);
    chk("R12 pipe miss shown during fill", 32'(mt_out), 32'd0);
    op_cmp(4'd10, 18'h2FACE);
    chk("R12 pipe fill stage high", 32'(mt_out), 32'd1);
    op_idle();
    chk("R12 pipe re-compare hits", 32'(mt_out), 32'd1);
  endtask

  initial begin : watchdog
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    t_reset();
    t_write_read();
    t_deselect();
    t_compare();
    t_hold_fill();
    t_enables();
    t_pipeline();
    t_collide();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule